// File: doc/BRIEF.md
# NMI Control and Gating Unit

This unit is the non-maskable interrupt front end of an interrupt controller. It brings an asynchronous NMI pin into the clock domain and detects a programmable edge on it. Depending on the CPU block bit and a pass-through control, it either presents each detected NMI to the CPU at once or holds it pending. It also drives a global mask for the ordinary interrupt sources while the pin is held low, and qualifies release from standby.

Software reaches the unit through one 16-bit control register on a simple write strobe plus a continuously driven read word. The CPU supplies its block bit and an acceptance strobe. The unit returns a request line, the global mask and the standby-release qualifier. Ordinary source arbitration, vectoring and the CPU status register are outside the block.

Top module: `nmi_gate_ctrl`

## Requirements
- R1: Register bit 15 reads the synchronized pin level (1 high, 0 low), two clocks behind the pin. Writes to it have no effect. Out of reset it reads 1, the idle pin level.
- R2: With bit 14 set, `int_mask` is 1 whenever the synchronized pin is low and 0 when it is high. With bit 14 clear and `standby` low, `int_mask` stays 0.
- R3: With bit 9 clear, an NMI detected while `cpu_bl` is 1 is held and keeps `nmi_req` low. `nmi_req` rises in the cycle `cpu_bl` returns to 0.
- R4: With bit 9 set, a detected NMI raises `nmi_req` three clocks after the pin change, even while `cpu_bl` is 1.
- R5: `nmi_ack` clears bit 9 at the next clock edge. This takes priority over a write in the same cycle.
- R6: While `standby` is 1 and the synchronized pin is low, `int_mask` is 1 and `wake_ok` is 0 whatever bit 14 holds. `wake_ok` = `standby` and pin high and (`nmi_req` or `irq_any`).
- R7: Bits 14, 9, 8 and 7 are writable, read back what was written, and reset to 0. Bits 13..10 and 6..0 always read 0.
- R8: Bit 8 selects the detected edge: 0 means falling, 1 means rising. An edge of the other direction raises no request.
- R9: `nmi_ack` clears the held NMI. An edge detected in the same cycle as `nmi_ack` sets it again.
- R10: Bit 7 is storage only. With it set, detection and forwarding behave exactly as with it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nmi_pin | input | 1 | Asynchronous NMI pin |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write data |
| reg_rdata | output | 16 | Control register read data |
| cpu_bl | input | 1 | CPU block bit |
| nmi_ack | input | 1 | NMI acceptance strobe from the CPU |
| standby | input | 1 | Standby mode indication |
| irq_any | input | 1 | Some ordinary interrupt source is requesting |
| nmi_req | output | 1 | NMI request to the CPU |
| int_mask | output | 1 | Global mask for ordinary interrupts |
| wake_ok | output | 1 | Standby-release qualifier |

## Verification
The sharpest corner is an acceptance strobe that lands on the very clock where a new edge is detected. A design that lets the clear win would drop that second NMI, and `nmi_req` would stay low once `cpu_bl` falls. The bench also holds an NMI behind `cpu_bl` for several cycles, where a design that ignores bit 9 would raise the request early. It drives a write of bit 9 together with acceptance, where a design with write priority would leave pass-through set. It brings the pin low in standby with bit 14 clear, where a mask tied only to bit 14 would let `wake_ok` through. Rising edges under falling selection, and the reverse, expose a swapped edge decode.

// File: rtl/nmi_gate_pkg.sv
package nmi_gate_pkg;
   localparam int REG_W      = 16;
   localparam int BIT_LEVEL  = 15;
   localparam int BIT_LOWMSK = 14;
   localparam int BIT_BYPASS = 9;
   localparam int BIT_RISE   = 8;
   localparam int BIT_SPARE  = 7;

   typedef struct packed {
      logic low_mask;
      logic bypass;
      logic rise_sel;
      logic spare;
   } nmi_ctrl_t;
endpackage

// File: rtl/nmi_sync_edge.sv
module nmi_sync_edge #(
   parameter int   STAGES   = 2,
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   input  logic rise_sel,
   output logic lvl,
   output logic edge_hit
);
   localparam int CHAIN_N = STAGES + 1;

   logic [CHAIN_N-1:0] chain;

   for (genvar s = 0; s < CHAIN_N; s++) begin : g_stage
      logic d_in;
      if (s == 0) begin : g_head
         assign d_in = pin_async;
      end else begin : g_tail
         assign d_in = chain[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= IDLE_LVL;
         else        chain[s] <= d_in;
      end
   end

   logic prev;
   assign lvl  = chain[STAGES-1];
   assign prev = chain[STAGES];

   always_comb begin
      if (rise_sel) edge_hit = lvl & ~prev;
      else          edge_hit = ~lvl & prev;
   end
endmodule

// File: rtl/nmi_ctrl_reg.sv
module nmi_ctrl_reg
   import nmi_gate_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   input  logic             ack,
   input  logic             lvl,
   output nmi_ctrl_t        ctrl,
   output logic [REG_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else begin
         if (we) begin
            ctrl.low_mask <= wdata[BIT_LOWMSK];
            ctrl.rise_sel <= wdata[BIT_RISE];
            ctrl.spare    <= wdata[BIT_SPARE];
            ctrl.bypass   <= wdata[BIT_BYPASS];
         end
         if (ack) ctrl.bypass <= 1'b0;
      end
   end

   always_comb begin
      rdata             = '0;
      rdata[BIT_LEVEL]  = lvl;
      rdata[BIT_LOWMSK] = ctrl.low_mask;
      rdata[BIT_BYPASS] = ctrl.bypass;
      rdata[BIT_RISE]   = ctrl.rise_sel;
      rdata[BIT_SPARE]  = ctrl.spare;
   end
endmodule

// File: rtl/nmi_req_gate.sv
module nmi_req_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_hit,
   input  logic ack,
   input  logic cpu_bl,
   input  logic bypass,
   input  logic lvl,
   input  logic low_mask,
   input  logic standby,
   input  logic irq_any,
   output logic nmi_req,
   output logic int_mask,
   output logic wake_ok
);
   logic held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held <= 1'b0;
      else        held <= (held & ~ack) | edge_hit;
   end

   assign nmi_req  = held & (~cpu_bl | bypass);
   assign int_mask = ~lvl & (low_mask | standby);
   assign wake_ok  = standby & lvl & (nmi_req | irq_any);
endmodule

// File: rtl/nmi_gate_ctrl.sv
module nmi_gate_ctrl
   import nmi_gate_pkg::*;
#(
   parameter int   SYNC_STAGES = 2,
   parameter logic PIN_IDLE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nmi_pin,
   input  logic             reg_we,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             cpu_bl,
   input  logic             nmi_ack,
   input  logic             standby,
   input  logic             irq_any,
   output logic             nmi_req,
   output logic             int_mask,
   output logic             wake_ok
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("nmi_gate_ctrl: SYNC_STAGES must be at least 2");
   end
   if (REG_W != 16) begin : g_bad_width
      $error("nmi_gate_ctrl: control register must be 16 bits");
   end

   nmi_ctrl_t ctrl;
   logic      lvl;
   logic      edge_hit;

   nmi_sync_edge #(.STAGES(SYNC_STAGES), .IDLE_LVL(PIN_IDLE)) i_sync (
      .clk(clk), .rst_n(rst_n), .pin_async(nmi_pin), .rise_sel(ctrl.rise_sel),
      .lvl(lvl), .edge_hit(edge_hit)
   );

   nmi_ctrl_reg i_reg (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata), .ack(nmi_ack),
      .lvl(lvl), .ctrl(ctrl), .rdata(reg_rdata)
   );

   nmi_req_gate i_gate (
      .clk(clk), .rst_n(rst_n), .edge_hit(edge_hit), .ack(nmi_ack),
      .cpu_bl(cpu_bl), .bypass(ctrl.bypass), .lvl(lvl), .low_mask(ctrl.low_mask),
      .standby(standby), .irq_any(irq_any), .nmi_req(nmi_req),
      .int_mask(int_mask), .wake_ok(wake_ok)
   );
endmodule

// File: rtl/nmi_gate_chk.sv
module nmi_gate_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] reg_rdata,
   input logic        cpu_bl,
   input logic        nmi_ack,
   input logic        standby,
   input logic        nmi_req,
   input logic        int_mask,
   input logic        wake_ok
);
   p_ack_clears_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_ack |=> !reg_rdata[9]);

   p_mask_low_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[14] && !reg_rdata[15]) |-> int_mask);

   p_unmask_high_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[15] |-> !int_mask);

   p_standby_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (standby && !reg_rdata[15]) |-> (int_mask && !wake_ok));

   p_blocked_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_bl && !reg_rdata[9]) |-> !nmi_req);

   p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[13:10] == 4'd0) && (reg_rdata[6:0] == 7'd0));
endmodule

bind nmi_gate_ctrl nmi_gate_chk i_chk (
   .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .cpu_bl(cpu_bl),
   .nmi_ack(nmi_ack), .standby(standby), .nmi_req(nmi_req),
   .int_mask(int_mask), .wake_ok(wake_ok)
);

// File: tb/test_nmi_gate_ctrl.sv
module test_nmi_gate_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_pin = 1'b1;
   logic        reg_we = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        cpu_bl = 1'b0;
   logic        nmi_ack = 1'b0;
   logic        standby = 1'b0;
   logic        irq_any = 1'b0;
   logic        nmi_req, int_mask, wake_ok;
   int          n_chk = 0;
   int          n_bad = 0;

   always #10 clk = ~clk;

   nmi_gate_ctrl i_nmi_gate_ctrl (
      .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_bl(cpu_bl),
      .nmi_ack(nmi_ack), .standby(standby), .irq_any(irq_any),
      .nmi_req(nmi_req), .int_mask(int_mask), .wake_ok(wake_ok)
   );

   // {write data, expected read data with the pin high}
   localparam logic [31:0] VEC [8] = '{
      {16'hFFFF, 16'hC380}, {16'h0000, 16'h8000}, {16'h4000, 16'hC000},
      {16'h0200, 16'h8200}, {16'h0100, 16'h8100}, {16'h0080, 16'h8080},
      {16'h3C7F, 16'h8000}, {16'h7FFF, 16'hC380}
   };

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] d);
      reg_we = 1'b1; reg_wdata = d;
      step(1);
      reg_we = 1'b0;
   endtask

   task automatic ack_pulse();
      nmi_ack = 1'b1;
      step(1);
      nmi_ack = 1'b0;
   endtask

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
      $finish;
   end

   initial begin
      step(3);
      chk("R1 reset level", reg_rdata, 16'h8000);
      chk("R7 reset req", {15'd0, nmi_req}, 16'd0);
      rst_n = 1'b1;
      step(2);

      foreach (VEC[i]) begin
         wr(VEC[i][31:16]);
         chk("R7 readback", reg_rdata, VEC[i][15:0]);
      end
      wr(16'h0000);

      // R8 falling edge, R2 no mask with bit 14 clear
      nmi_pin = 1'b0;
      step(2);
      chk("R1 level low", reg_rdata, 16'h0000);
      chk("R2 no mask", {15'd0, int_mask}, 16'd0);
      step(1);
      chk("R8 falling req", {15'd0, nmi_req}, 16'd1);
      ack_pulse();
      chk("R9 ack clears", {15'd0, nmi_req}, 16'd0);
      nmi_pin = 1'b1;
      step(4);

      // R2 mask with bit 14
      wr(16'h4000);
      nmi_pin = 1'b0;
      step(2);
      chk("R2 mask low", {15'd0, int_mask}, 16'd1);
      nmi_pin = 1'b1;
      step(2);
      chk("R2 unmask high", {15'd0, int_mask}, 16'd0);
      step(2);
      ack_pulse();
      wr(16'h0000);

      // R3 held behind block bit
      cpu_bl = 1'b1;
      nmi_pin = 1'b0;
      step(6);
      chk("R3 held", {15'd0, nmi_req}, 16'd0);
      cpu_bl = 1'b0;
      #1;
      chk("R3 release", {15'd0, nmi_req}, 16'd1);
      step(1);
      ack_pulse();
      nmi_pin = 1'b1;
      step(4);

      // R4 pass-through with R10 spare bit set
      wr(16'h0280);
      cpu_bl = 1'b1;
      nmi_pin = 1'b0;
      step(2);
      chk("R4 early", {15'd0, nmi_req}, 16'd0);
      step(1);
      chk("R4 R10 immediate", {15'd0, nmi_req}, 16'd1);
      ack_pulse();
      chk("R5 bypass cleared", reg_rdata, 16'h0080);
      chk("R9 req gone", {15'd0, nmi_req}, 16'd0);
      cpu_bl = 1'b0;
      nmi_pin = 1'b1;
      step(4);

      // R5 ack beats write
      reg_we = 1'b1; reg_wdata = 16'h0200; nmi_ack = 1'b1;
      step(1);
      reg_we = 1'b0; nmi_ack = 1'b0;
      chk("R5 ack priority", reg_rdata, 16'h8000);

      // R8 rising select
      wr(16'h0100);
      nmi_pin = 1'b0;
      step(4);
      chk("R8 falling ignored", {15'd0, nmi_req}, 16'd0);
      nmi_pin = 1'b1;
      step(3);
      chk("R8 rising req", {15'd0, nmi_req}, 16'd1);
      ack_pulse();
      wr(16'h0000);

      // R9 ack coincident with new edge
      cpu_bl = 1'b1;
      nmi_pin = 1'b0;
      step(4);
      nmi_pin = 1'b1;
      step(4);
      nmi_pin = 1'b0;
      step(2);
      nmi_ack = 1'b1;
      step(1);
      nmi_ack = 1'b0;
      cpu_bl = 1'b0;
      #1;
      chk("R9 edge kept", {15'd0, nmi_req}, 16'd1);
      step(1);
      ack_pulse();
      nmi_pin = 1'b1;
      step(4);

      // R6 standby
      standby = 1'b1; irq_any = 1'b1;
      step(1);
      chk("R6 wake high pin", {15'd0, wake_ok}, 16'd1);
      nmi_pin = 1'b0;
      step(2);
      chk("R6 wake blocked", {15'd0, wake_ok}, 16'd0);
      chk("R6 standby mask", {15'd0, int_mask}, 16'd1);
      nmi_pin = 1'b1;
      step(2);
      chk("R6 wake restored", {15'd0, wake_ok}, 16'd1);
      standby = 1'b0; irq_any = 1'b0;
      step(1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule